// File: doc/BRIEF.md
# Dual-ADC Output Test Pattern Generator

This block sits between the four 8-bit output lanes of a dual converter and the output pins. It can put known data on those pins in place of samples so that board wiring and receivers can be checked without an analog source. Port A carries an in-phase and a quadrature lane, and port B carries another such pair. A single configuration word, loaded elsewhere from a serial register, selects what the pins carry. In pass-through the pins carry the converter samples. In static test the pins carry a programmed byte and its complement. In dynamic test they carry two ramps that run in opposite directions.

In both test modes port B carries the "true" value and port A carries its bitwise inverse, so every output pin toggles against its neighbour on the other port. The rising ramp advances once per sample clock. It starts again from zero each time dynamic test is entered. Every output lane is registered, so a configuration or sample change shows at the pins one clock after it is presented. Dynamic test is meant for sample clocks up to 750 Msps.

Top module: `adc_selftest_mux`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four output lanes become 0x00 after that edge. After release the block is in pass-through until the configuration word selects a test mode.
- R2: With `cfg_word[0]` = 0, each output lane equals its converter input from the previous clock edge. `cfg_word[1]` and `cfg_word[9:2]` have no effect on the outputs.
- R3: With `cfg_word[1:0]` = 2'b01 (static test), `out_bi` and `out_bq` equal `cfg_word[9:2]` from the previous edge. `cfg_word[2]` maps to output bit 0.
- R4: In static test, `out_ai` and `out_aq` equal the bitwise inverse of `cfg_word[9:2]` from the previous edge.
- R5: With `cfg_word[1:0]` = 2'b11 (dynamic test), `out_bi` rises by one on every clock and wraps from 0xFF to 0x00.
- R6: In dynamic test, `out_ai` is the bitwise inverse of `out_bi`, which makes it a falling ramp.
- R7: On the first clock edge at which dynamic test is selected, port B shows 0x00 and port A shows 0xFF. This holds after any other mode and after reset.
- R8: In both test modes the I and Q lanes of one port carry identical values.
- R9: A change of the configuration word shows at the outputs one clock after it is applied, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 10 | Bit 0 test enable, bit 1 dynamic select, bits 9:2 static byte |
| conv_ai | input | 8 | Converter sample, port A in-phase |
| conv_aq | input | 8 | Converter sample, port A quadrature |
| conv_bi | input | 8 | Converter sample, port B in-phase |
| conv_bq | input | 8 | Converter sample, port B quadrature |
| out_ai | output | 8 | Output lane, port A in-phase |
| out_aq | output | 8 | Output lane, port A quadrature |
| out_bi | output | 8 | Output lane, port B in-phase |
| out_bq | output | 8 | Output lane, port B quadrature |

## Verification
Some relations hold from one cycle to the next, and the assertions check them on every clock. These are the pass-through delay, the static byte and its inverse, the plus-one step of the ramp, the complement between ports, the equality of I and Q, and the zero start on entry to dynamic test. Other properties need a scenario to show them, and the bench provides these. Crossing the 0xFF to 0x00 wrap takes a long run of dynamic cycles. Leaving dynamic test and coming back must restart the ramp. Random mode and pattern bits must have no effect while the test is disabled. A reset applied in the middle of a ramp must also be shown to return the block to pass-through.

// File: rtl/tp_pkg.sv
// Package: shared types for the dual-ADC test pattern generator.
// Assumes: the configuration word is enable, mode select, then the pattern byte.
package tp_pkg;
    typedef enum logic [1:0] {
        TP_PASS   = 2'd0,
        TP_STATIC = 2'd1,
        TP_RAMP   = 2'd2
    } tp_mode_e;

    localparam int unsigned TP_LANES = 4;
    // Lane order: 0 = A in-phase, 1 = A quadrature, 2 = B in-phase, 3 = B quadrature
    localparam int unsigned TP_FIRST_B_LANE = 2;
endpackage

// File: rtl/tp_cfg_decode.sv
// Module: tp_cfg_decode
// Splits the configuration word into an operating mode and a pattern byte.
// Assumes: bit 0 enables test, bit 1 picks the ramp, bits above carry the byte.
module tp_cfg_decode
    import tp_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CFG_W = DATA_W + 2
) (
    input  logic [CFG_W-1:0]  cfg_word,
    output tp_mode_e          mode,
    output logic [DATA_W-1:0] pattern
);
    // Purpose: map enable and mode-select bits onto the mode enum
    always_comb begin
        if (!cfg_word[0])     mode = TP_PASS;
        else if (cfg_word[1]) mode = TP_RAMP;
        else                  mode = TP_STATIC;
    end

    assign pattern = cfg_word[CFG_W-1:2];
endmodule

// File: rtl/tp_ramp_gen.sv
// Module: tp_ramp_gen
// Free-running up counter that runs only in ramp mode and sits at zero otherwise,
// so every entry into ramp mode starts from zero.
// Assumes: synchronous active-low reset; wraps naturally at full scale.
module tp_ramp_gen #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [DATA_W-1:0] ramp
);
    logic [DATA_W-1:0] count_q;

    // Purpose: count while running, otherwise hold the start value
    always_ff @(posedge clk) begin
        if (!rst_n)   count_q <= '0;
        else if (run) count_q <= count_q + 1'b1;
        else          count_q <= '0;
    end

    assign ramp = count_q;
endmodule

// File: rtl/tp_lane_reg.sv
// Module: tp_lane_reg
// One registered output lane: selects converter data or the test value for this lane.
// Assumes: the caller has already applied any inversion to test_val.
module tp_lane_reg
    import tp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tp_mode_e          mode,
    input  logic [DATA_W-1:0] conv,
    input  logic [DATA_W-1:0] test_val,
    output logic [DATA_W-1:0] lane_out
);
    // Purpose: register the selected lane value
    always_ff @(posedge clk) begin
        if (!rst_n)               lane_out <= '0;
        else if (mode == TP_PASS) lane_out <= conv;
        else                      lane_out <= test_val;
    end
endmodule

// File: rtl/adc_selftest_mux.sv
// Module: adc_selftest_mux (top)
// Replaces the four converter output lanes with a static byte/inverse pair or
// opposing ramps, as chosen by the configuration word; otherwise passes samples.
// Assumes: cfg_word is stable around the sample clock edge; outputs lag by one edge.
module adc_selftest_mux
    import tp_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CFG_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [DATA_W-1:0] conv_ai,
    input  logic [DATA_W-1:0] conv_aq,
    input  logic [DATA_W-1:0] conv_bi,
    input  logic [DATA_W-1:0] conv_bq,
    output logic [DATA_W-1:0] out_ai,
    output logic [DATA_W-1:0] out_aq,
    output logic [DATA_W-1:0] out_bi,
    output logic [DATA_W-1:0] out_bq
);
    tp_mode_e          mode;
    logic [DATA_W-1:0] pattern;
    logic [DATA_W-1:0] ramp;
    logic [DATA_W-1:0] true_val;
    logic [DATA_W-1:0] conv_arr [TP_LANES];
    logic [DATA_W-1:0] out_arr  [TP_LANES];

    tp_cfg_decode #(.DATA_W(DATA_W)) u_decode (
        .cfg_word (cfg_word),
        .mode     (mode),
        .pattern  (pattern)
    );

    tp_ramp_gen #(.DATA_W(DATA_W)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mode == TP_RAMP),
        .ramp  (ramp)
    );

    // Purpose: pick the port B value for the active test mode
    always_comb begin
        true_val = (mode == TP_RAMP) ? ramp : pattern;
    end

    assign conv_arr[0] = conv_ai;
    assign conv_arr[1] = conv_aq;
    assign conv_arr[2] = conv_bi;
    assign conv_arr[3] = conv_bq;

    for (genvar g = 0; g < TP_LANES; g++) begin : g_lane
        localparam bit INVERT = (g < TP_FIRST_B_LANE);
        tp_lane_reg #(.DATA_W(DATA_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode),
            .conv     (conv_arr[g]),
            .test_val (INVERT ? ~true_val : true_val),
            .lane_out (out_arr[g])
        );
    end

    assign out_ai = out_arr[0];
    assign out_aq = out_arr[1];
    assign out_bi = out_arr[2];
    assign out_bq = out_arr[3];
endmodule

// File: rtl/adc_selftest_mux_chk.sv
// Module: adc_selftest_mux_chk
// Port-level protocol checks for adc_selftest_mux, bound to every instance.
// Assumes: 8-bit lanes and the configuration bit layout of the top module.
module adc_selftest_mux_chk #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CFG_W = DATA_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_W-1:0]  cfg_word,
    input logic [DATA_W-1:0] conv_ai,
    input logic [DATA_W-1:0] conv_aq,
    input logic [DATA_W-1:0] conv_bi,
    input logic [DATA_W-1:0] conv_bq,
    input logic [DATA_W-1:0] out_ai,
    input logic [DATA_W-1:0] out_aq,
    input logic [DATA_W-1:0] out_bi,
    input logic [DATA_W-1:0] out_bq
);
    logic dyn;
    logic stat;
    logic dyn_prev_q;

    assign dyn  = cfg_word[0] & cfg_word[1];
    assign stat = cfg_word[0] & ~cfg_word[1];

    // Purpose: remember whether the previous edge was in ramp mode
    always_ff @(posedge clk) begin
        if (!rst_n) dyn_prev_q <= 1'b0;
        else        dyn_prev_q <= dyn;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (out_ai == '0 && out_aq == '0 && out_bi == '0 && out_bq == '0));

    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_word[0] |=> (out_ai == $past(conv_ai) && out_aq == $past(conv_aq) &&
                          out_bi == $past(conv_bi) && out_bq == $past(conv_bq)));

    a_r3_static_port_b: assert property (@(posedge clk) disable iff (!rst_n)
        stat |=> (out_bi == $past(cfg_word[CFG_W-1:2])));

    a_r4_static_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        stat |=> (out_ai == ~$past(cfg_word[CFG_W-1:2])));

    a_r5_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dyn && dyn_prev_q) |=> (out_bi == DATA_W'($past(out_bi) + 1'b1)));

    a_r6_ramp_complement: assert property (@(posedge clk) disable iff (!rst_n)
        dyn |=> (out_ai == ~out_bi));

    a_r7_ramp_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (dyn && !dyn_prev_q) |=> (out_bi == '0 && out_ai == '1));

    a_r8_lanes_match: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[0] |=> (out_ai == out_aq && out_bi == out_bq));
endmodule

bind adc_selftest_mux adc_selftest_mux_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .conv_ai  (conv_ai),
    .conv_aq  (conv_aq),
    .conv_bi  (conv_bi),
    .conv_bq  (conv_bq),
    .out_ai   (out_ai),
    .out_aq   (out_aq),
    .out_bi   (out_bi),
    .out_bq   (out_bq)
);

// File: tb/test_adc_selftest_mux.sv
// Bench for adc_selftest_mux: seeded random plus directed corners against a bench model.
module test_adc_selftest_mux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] cfg_word = '0;
    logic [7:0] conv_ai = '0, conv_aq = '0, conv_bi = '0, conv_bq = '0;
    logic [7:0] out_ai, out_aq, out_bi, out_bq;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic [7:0]  exp_ramp = '0;
    logic        was_ramp = 1'b0;
    logic        done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    adc_selftest_mux i_adc_selftest_mux (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .conv_ai(conv_ai), .conv_aq(conv_aq), .conv_bi(conv_bi), .conv_bq(conv_bq),
        .out_ai(out_ai), .out_aq(out_aq), .out_bi(out_bi), .out_bq(out_bq)
    );

    function automatic logic [31:0] pack4(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [7:0] d);
        return {a, b, c, d};
    endfunction

    // Expected {ai, aq, bi, bq} after one edge, from the requirements; updates the ramp model.
    function automatic logic [31:0] expect_next(logic rst, logic [9:0] cfg,
                                                logic [31:0] conv);
        logic [7:0] b;
        if (!rst) begin
            was_ramp = 1'b0;
            return '0;
        end
        if (!cfg[0]) begin
            was_ramp = 1'b0;
            return conv;
        end
        if (cfg[1]) begin
            exp_ramp = was_ramp ? exp_ramp + 8'd1 : 8'd0;
            was_ramp = 1'b1;
            b = exp_ramp;
        end else begin
            was_ramp = 1'b0;
            b = cfg[9:2];
        end
        return pack4(~b, ~b, b, b);
    endfunction

    task automatic step(input logic rst, input logic [9:0] cfg, input string req);
        logic [31:0] exp_v, got;
        @(negedge clk);
        rst_n    = rst;
        cfg_word = cfg;
        conv_ai  = 8'($urandom);
        conv_aq  = 8'($urandom);
        conv_bi  = 8'($urandom);
        conv_bq  = 8'($urandom);
        exp_v = expect_next(rst, cfg, pack4(conv_ai, conv_aq, conv_bi, conv_bq));
        @(posedge clk);
        #1;
        got = pack4(out_ai, out_aq, out_bi, out_bq);
        n_checks++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp_v);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        step(1'b0, 10'h3FF, "R1");
        step(1'b0, 10'h000, "R1");
        // R2: pass-through with random mode and pattern bits, enable low
        for (int i = 0; i < 40; i++)
            step(1'b1, {9'($urandom), 1'b0}, "R2");
        // R3 R4 R8: static directed corners
        step(1'b1, {8'h00, 2'b01}, "R3");
        step(1'b1, {8'hFF, 2'b01}, "R4");
        step(1'b1, {8'hA5, 2'b01}, "R8");
        step(1'b1, {8'h01, 2'b01}, "R3");   // cfg_word[2] -> output bit 0
        // R9: random static patterns change on each edge
        for (int i = 0; i < 40; i++)
            step(1'b1, {8'($urandom), 2'b01}, "R9");
        // R7 R5 R6: dynamic entry then run past the wrap
        step(1'b1, {8'h5A, 2'b11}, "R7");
        for (int i = 0; i < 300; i++)
            step(1'b1, {8'($urandom), 2'b11}, "R5");
        // R7: leave to static, then return; ramp restarts
        step(1'b1, {8'h33, 2'b01}, "R4");
        step(1'b1, {8'h33, 2'b11}, "R7");
        for (int i = 0; i < 20; i++)
            step(1'b1, 10'h003, "R6");
        // R7: leave to pass-through, then return
        step(1'b1, 10'h002, "R2");
        step(1'b1, 10'h003, "R7");
        step(1'b1, 10'h003, "R5");
        // R1: reset in the middle of a ramp, then pass-through after release
        step(1'b0, 10'h003, "R1");
        step(1'b1, 10'h000, "R1");
        step(1'b1, 10'h003, "R7");
        // mixed random tail
        for (int i = 0; i < 200; i++)
            step(($urandom % 50) != 0, 10'($urandom), "R9");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule